// File: doc/BRIEF.md
# Hysteretic Digital PLL Lock Detector

This block turns the phase-error activity of a phase/frequency detector into a clean lock flag. Its input is the NOR of the detector's up and down pulses: the line sits high while the charge pump is idle and falls low for as long as either pump pulse is on. The width of each low pulse is therefore the phase error of that comparison cycle plus the antibacklash time. The block counts each low pulse in system clock cycles. The count is compared against two programmable thresholds when the pulse ends.

While unlocked, the detector needs an unbroken run of in-window comparison cycles before it raises the lock flag. A select input sets the run length to three or five cycles. Once locked, the flag ignores moderate errors. It falls as soon as one comparison cycle exceeds the wider loss threshold. The two thresholds form a hysteresis band that stops the flag from chattering when the error sits near the lock window. The last measured width is also brought out for debug.

Top module: `lock_hyst_det`

## Requirements
- R1: A pulse of N consecutive clock samples with `pfd_nor` low, followed by a high sample, gives `width_o` = N on the cycle after that first high sample. `width_o` holds its value until the next pulse ends.
- R2: The width count saturates at 2^CNT_W-1 (255 by default). A longer pulse reports 255.
- R3: A pulse is in the lock window when its width is less than or equal to `win_thr`. With `prec_sel` = 0, the third consecutive in-window pulse raises `lock_o`.
- R4: With `prec_sel` = 1, the fifth consecutive in-window pulse raises `lock_o`, and four in-window pulses do not.
- R5: While unlocked, a pulse wider than `win_thr` restarts the run count from zero.
- R6: While locked, a pulse wider than `win_thr` but not wider than the loss threshold leaves `lock_o` high.
- R7: While locked, one pulse wider than the loss threshold clears `lock_o` on the cycle after that pulse ends.
- R8: When `loss_thr` is less than or equal to `win_thr`, the loss threshold used is `win_thr`.
- R9: `lock_o` changes only on the cycle after a pulse ends. It never changes while `pfd_nor` stays low or stays high.
- R10: A synchronous active-high `rst` clears `lock_o`, `width_o` and the run count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pfd_nor | input | 1 | NOR of up/down pump pulses; low means a pump pulse is active |
| win_thr | input | CNT_W | Lock window, in clock cycles |
| loss_thr | input | CNT_W | Loss-of-lock threshold, in clock cycles |
| prec_sel | input | 1 | Run length select: 0 gives 3 cycles, 1 gives 5 cycles |
| lock_o | output | 1 | Registered lock flag |
| width_o | output | CNT_W | Width of the last completed pulse |

## Verification
The bound checker watches every cycle for four properties. The flag and the debug width move only right after a pulse ends. A rise of the flag always follows an in-window width. A fall always follows a width beyond both thresholds. A locked detector that sees a width within the loss threshold stays locked. It also checks that the width counter holds at its maximum during a long pulse. Only the directed scenarios can show the run lengths of three and five, the restart of a broken run, the clamp of a loss threshold set below the window, and the clearing of a partial run by reset. These behaviours depend on a history of several pulses, so the bench drives known pulse trains and compares against the values the requirements predict.

// File: rtl/lkd_pkg.sv
`timescale 1ns/1ps
package lkd_pkg;
   typedef enum logic {
      LK_HUNT   = 1'b0,
      LK_LOCKED = 1'b1
   } lk_state_e;
endpackage

// File: rtl/lkd_pulse_meter.sv
`timescale 1ns/1ps
module lkd_pulse_meter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             act_n,
   output logic             end_evt,
   output logic [CNT_W-1:0] meas_cnt,
   output logic [CNT_W-1:0] width_q
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic act_n_q;

   // A pulse ends on the first high sample after at least one low sample.
   assign end_evt = act_n && !act_n_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         act_n_q  <= 1'b1;
         meas_cnt <= '0;
         width_q  <= '0;
      end else begin
         act_n_q <= act_n;
         if (!act_n) begin
            if (meas_cnt != CNT_MAX)
               meas_cnt <= meas_cnt + 1'b1;
         end else begin
            meas_cnt <= '0;
         end
         if (end_evt)
            width_q <= meas_cnt;
      end
   end
endmodule

// File: rtl/lkd_lock_fsm.sv
`timescale 1ns/1ps
module lkd_lock_fsm
   import lkd_pkg::*;
#(
   parameter int CNT_W     = 8,
   parameter int SHORT_RUN = 3,
   parameter int LONG_RUN  = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             end_evt,
   input  logic [CNT_W-1:0] meas,
   input  logic [CNT_W-1:0] win_thr,
   input  logic [CNT_W-1:0] loss_thr,
   input  logic             prec_sel,
   output logic             locked
);
   localparam int RUN_W = $clog2(LONG_RUN + 1);
   localparam logic [RUN_W-1:0] SHORT_N = RUN_W'(SHORT_RUN);
   localparam logic [RUN_W-1:0] LONG_N  = RUN_W'(LONG_RUN);

   generate
      if (SHORT_RUN < 1 || LONG_RUN < SHORT_RUN) begin : g_bad_run
         $error("lkd_lock_fsm: run lengths must satisfy 1 <= SHORT_RUN <= LONG_RUN");
      end
      if (CNT_W < 2) begin : g_bad_w
         $error("lkd_lock_fsm: CNT_W must be at least 2");
      end
   endgenerate

   lk_state_e        state;
   logic [RUN_W-1:0] run_cnt;
   logic [RUN_W-1:0] need;
   logic [CNT_W-1:0] loss_eff;
   logic             in_win;
   logic             too_wide;

   assign need     = prec_sel ? LONG_N : SHORT_N;
   assign loss_eff = (loss_thr > win_thr) ? loss_thr : win_thr;
   assign in_win   = (meas <= win_thr);
   assign too_wide = (meas > loss_eff);
   assign locked   = (state == LK_LOCKED);

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= LK_HUNT;
         run_cnt <= '0;
      end else if (end_evt) begin
         case (state)
            LK_HUNT: begin
               if (in_win) begin
                  if (run_cnt + 1'b1 >= need) begin
                     state   <= LK_LOCKED;
                     run_cnt <= '0;
                  end else begin
                     run_cnt <= run_cnt + 1'b1;
                  end
               end else begin
                  run_cnt <= '0;
               end
            end
            default: begin
               if (too_wide) begin
                  state   <= LK_HUNT;
                  run_cnt <= '0;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/lock_hyst_det.sv
`timescale 1ns/1ps
module lock_hyst_det #(
   parameter int CNT_W     = 8,
   parameter int SHORT_RUN = 3,
   parameter int LONG_RUN  = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             pfd_nor,
   input  logic [CNT_W-1:0] win_thr,
   input  logic [CNT_W-1:0] loss_thr,
   input  logic             prec_sel,
   output logic             lock_o,
   output logic [CNT_W-1:0] width_o
);
   logic             end_evt;
   logic [CNT_W-1:0] meas_cnt;

   lkd_pulse_meter #(.CNT_W(CNT_W)) u_meter (
      .clk      (clk),
      .rst      (rst),
      .act_n    (pfd_nor),
      .end_evt  (end_evt),
      .meas_cnt (meas_cnt),
      .width_q  (width_o)
   );

   lkd_lock_fsm #(
      .CNT_W     (CNT_W),
      .SHORT_RUN (SHORT_RUN),
      .LONG_RUN  (LONG_RUN)
   ) u_fsm (
      .clk      (clk),
      .rst      (rst),
      .end_evt  (end_evt),
      .meas     (meas_cnt),
      .win_thr  (win_thr),
      .loss_thr (loss_thr),
      .prec_sel (prec_sel),
      .locked   (lock_o)
   );
endmodule

// File: rtl/lkd_chk.sv
`timescale 1ns/1ps
module lkd_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             pfd_nor,
   input logic [CNT_W-1:0] win_thr,
   input logic [CNT_W-1:0] loss_thr,
   input logic             lock_o,
   input logic [CNT_W-1:0] width_o,
   input logic             end_evt,
   input logic [CNT_W-1:0] meas_cnt
);
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   // R9: the flag moves only on the cycle after a low-to-high transition
   p_lock_on_end_r9: assert property (@(posedge clk) disable iff (rst)
      !$stable(lock_o) |-> ($past(pfd_nor) && !$past(pfd_nor, 2)));

   // R1: the debug width is updated only when a pulse has just ended
   p_width_hold_r1: assert property (@(posedge clk) disable iff (rst)
      !$stable(width_o) |-> ($past(pfd_nor) && !$past(pfd_nor, 2)));

   // R3: a rising flag follows a width inside the window
   p_rise_in_win_r3: assert property (@(posedge clk) disable iff (rst)
      $rose(lock_o) |-> (width_o <= $past(win_thr)));

   // R7/R8: a falling flag follows a width beyond both thresholds
   p_fall_beyond_r7: assert property (@(posedge clk) disable iff (rst)
      $fell(lock_o) |-> (width_o > $past(win_thr) && width_o > $past(loss_thr)));

   // R6: locked and width within the effective loss threshold keeps the flag
   p_hold_band_r6: assert property (@(posedge clk) disable iff (rst)
      (lock_o && end_evt && (meas_cnt <= win_thr || meas_cnt <= loss_thr)) |=> lock_o);

   // R2: the counter holds at its ceiling while the pulse continues
   p_sat_r2: assert property (@(posedge clk) disable iff (rst)
      (meas_cnt == CMAX && !pfd_nor) |=> (meas_cnt == CMAX));
endmodule

bind lock_hyst_det lkd_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .pfd_nor  (pfd_nor),
   .win_thr  (win_thr),
   .loss_thr (loss_thr),
   .lock_o   (lock_o),
   .width_o  (width_o),
   .end_evt  (end_evt),
   .meas_cnt (meas_cnt)
);

// File: tb/sim_lock_hyst_det.sv
`timescale 1ns/1ps
module sim_lock_hyst_det;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       pfd_nor = 1'b1;
   logic [7:0] win_thr = 8'd15;
   logic [7:0] loss_thr = 8'd30;
   logic       prec_sel = 1'b0;
   logic       lock_o;
   logic [7:0] width_o;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   lock_hyst_det u0 (
      .clk(clk), .rst(rst), .pfd_nor(pfd_nor), .win_thr(win_thr),
      .loss_thr(loss_thr), .prec_sel(prec_sel), .lock_o(lock_o), .width_o(width_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      pfd_nor = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
   endtask

   // low for w samples, then high; returns at the negedge after the end edge
   task automatic pulse(input int w);
      pfd_nor = 1'b0;
      repeat (w) @(negedge clk);
      pfd_nor = 1'b1;
      @(negedge clk);
   endtask

   task automatic gap();
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      do_reset();
      chk("R10 reset lock", lock_o, 0);
      chk("R10 reset width", width_o, 0);
   endtask

   task automatic t_width();
      do_reset();
      pulse(7);
      chk("R1 width 7", width_o, 7);
      gap();
      chk("R1 width held", width_o, 7);
      pulse(1);
      chk("R1 width 1", width_o, 1);
   endtask

   task automatic t_sat();
      do_reset();
      pulse(300);
      chk("R2 saturated width", width_o, 255);
   endtask

   task automatic t_lock3();
      do_reset();
      win_thr = 15; loss_thr = 30; prec_sel = 0;
      pulse(10); gap();
      pulse(15); gap();
      chk("R3 two pulses no lock", lock_o, 0);
      pfd_nor = 1'b0;
      repeat (5) @(negedge clk);
      chk("R9 no change mid pulse", lock_o, 0);
      pfd_nor = 1'b1;
      @(negedge clk);
      chk("R3 third pulse locks", lock_o, 1);
   endtask

   task automatic t_hyst();
      pulse(25); gap();
      chk("R6 band keeps lock", lock_o, 1);
      pulse(30); gap();
      chk("R6 equal loss keeps lock", lock_o, 1);
      pfd_nor = 1'b0;
      repeat (31) @(negedge clk);
      chk("R9 hold during long pulse", lock_o, 1);
      pfd_nor = 1'b1;
      @(negedge clk);
      chk("R7 drop after wide pulse", lock_o, 0);
   endtask

   task automatic t_restart();
      do_reset();
      prec_sel = 0;
      pulse(5); gap(); pulse(5); gap();
      pulse(20); gap();
      pulse(5); gap(); pulse(5); gap();
      chk("R5 run restarted", lock_o, 0);
      pulse(5); gap();
      chk("R5 lock after fresh run", lock_o, 1);
   endtask

   task automatic t_lock5();
      do_reset();
      prec_sel = 1;
      for (int i = 0; i < 4; i++) begin pulse(8); gap(); end
      chk("R4 four pulses no lock", lock_o, 0);
      pulse(8); gap();
      chk("R4 fifth pulse locks", lock_o, 1);
      prec_sel = 0;
   endtask

   task automatic t_clamp();
      do_reset();
      win_thr = 15; loss_thr = 5; prec_sel = 0;
      for (int i = 0; i < 3; i++) begin pulse(12); gap(); end
      chk("R8 locked with low loss", lock_o, 1);
      pulse(15); gap();
      chk("R8 width at window keeps", lock_o, 1);
      pulse(16); gap();
      chk("R8 width above window drops", lock_o, 0);
      loss_thr = 30;
   endtask

   task automatic t_rst_run();
      do_reset();
      prec_sel = 0;
      for (int i = 0; i < 3; i++) begin pulse(4); gap(); end
      chk("R10 locked before reset", lock_o, 1);
      pulse(4); gap(); pulse(4); gap();
      do_reset();
      chk("R10 reset clears lock", lock_o, 0);
      pulse(4); gap(); pulse(4); gap();
      chk("R10 run cleared by reset", lock_o, 0);
   endtask

   task automatic finish_sim();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_sim();
   end

   initial begin
      t_reset();
      t_width();
      t_sat();
      t_lock3();
      t_hyst();
      t_restart();
      t_lock5();
      t_clamp();
      t_rst_run();
      finish_sim();
   end
endmodule